// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock into one output per channel. Each output's high time and low time are set separately, anywhere from 1 to 16 input cycles, so both the ratio and the duty cycle are programmable. All channels share one sync input. A channel that obeys sync holds its output at an idle level while sync is high. After sync is released, the channel waits a programmed number of input cycles and then starts in the chosen phase. This lets channels with different offsets keep a fixed skew to each other.

Configuration arrives as plain field inputs. It is copied into each channel's working copy only on cycles where sync is high, so a change can never cut a pulse short in the middle of a period. Per channel, the output can also be:
- forced to a static high level, when the channel also ignores sync, or
- bypassed, which routes the input clock straight to the output and idles the counter.

Top module: `duty_clk_div`

## Requirements
- R1: While running, each high interval of a channel output lasts (high-length field + 1) input cycles, where the high-length field is 4 bits wide, giving 1 to 16 cycles.
- R2: While running, each low interval lasts (low-length field + 1) input cycles, where the low-length field is 4 bits wide, giving 1 to 16 cycles.
- R3: While sync is high and obeyed, the output sits at the idle level, which is the inverse of the start-level bit. When running begins, the first interval has the start level (1 = high first, 0 = low first).
- R4: Suppose sync is sampled high at one rising edge and low at the next rising edge E. The output then takes the start level after rising edge E + p, where p is the 4-bit phase field. As a result, two channels released by the same sync pulse show start points p apart.
- R5: A channel whose nosync bit is 1 on the sync cycle ignores sync. Its waveform continues with no restart and no change in run lengths.
- R6: When the working nosync bit and force bit are both 1 (and bypass is 0), the output is constantly high. With nosync 0, the force bit has no effect on the waveform.
- R7: When the working bypass bit is 1, the output equals the input clock in both clock phases, regardless of the force bit.
- R8: Field inputs take effect only on cycles where sync is high. Changing them at any other time leaves the waveform unchanged.
- R9: After reset, each channel takes the following defaults, and the output stays at the idle level (high) during reset:

  | Channels | Bypass | High/low lengths | Start level | Phase |
  |---|---|---|---|---|
  | Even | on | 0 | low | 0 |
  | Odd | off | 11 each (divide by 24, 50% duty) | low | 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Shared sync; high captures configuration and restarts obeying channels |
| cfg_lo_len_i | input | NCH*4 | Per-channel low length minus one |
| cfg_hi_len_i | input | NCH*4 | Per-channel high length minus one |
| cfg_phase_i | input | NCH*4 | Per-channel start delay after sync release, in input cycles |
| cfg_start_i | input | NCH | Per-channel start level (1 = high) |
| cfg_nosync_i | input | NCH | Per-channel sync ignore |
| cfg_force_i | input | NCH | Per-channel static-high request, honoured only with nosync |
| cfg_bypass_i | input | NCH | Per-channel pass-through of the input clock |
| clk_o | output | NCH | Divided clock outputs |

## Verification
A sync pulse can land on the same cycle in which a channel's counter expires and its level toggles. Two behaviours must then both hold:
- An obeying channel must give the restart priority over the toggle.
- A channel that ignores sync must take the toggle and must also capture the unchanged fields without disturbing the count.

The sweep over all 256 length pairs uses random offsets and start levels. This places restarts at arbitrary points of the previous waveform, and every sample is compared against a computed reference. A directed window drops a sync pulse into the middle of a running, sync-ignoring channel, and every complete run on both sides of the pulse is checked for the exact length.

// File: rtl/duty_div_pkg.sv
`timescale 1ns/1ps
package duty_div_pkg;

  localparam int CW = 4;

  typedef struct packed {
    logic          bypass;
    logic          nosync;
    logic          force_hi;
    logic          start_hi;
    logic [CW-1:0] phase;
    logic [CW-1:0] hi_len;
    logic [CW-1:0] lo_len;
  } div_cfg_t;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_t;

  // Even channels wake up as pass-through, odd channels as a 24:1 square wave.
  function automatic div_cfg_t reset_cfg(int ch);
    div_cfg_t c;
    c = '0;
    if (ch % 2 == 0) begin
      c.bypass = 1'b1;
    end else begin
      c.hi_len = CW'(11);
      c.lo_len = CW'(11);
    end
    return c;
  endfunction

endpackage

// File: rtl/duty_rst_sync.sv
`timescale 1ns/1ps
module duty_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/duty_cfg_hold.sv
`timescale 1ns/1ps
module duty_cfg_hold
  import duty_div_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     capture_i,
  input  div_cfg_t cfg_i,
  output div_cfg_t cfg_o
);

  div_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (capture_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= RST_CFG;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/duty_seq.sv
`timescale 1ns/1ps
module duty_seq
  import duty_div_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_cfg_t cfg_i,
  input  logic     sync_hit_i,
  input  logic     sync_start_i,
  output logic     lvl_o,
  output logic     run_o
);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] first_len;
  logic          parked;

  assign first_len = cfg_i.start_hi ? cfg_i.hi_len : cfg_i.lo_len;
  assign parked    = cfg_i.bypass | (cfg_i.nosync & cfg_i.force_hi);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (sync_hit_i) begin
      st_d  = ST_HOLD;
      cnt_d = '0;
      lvl_d = ~sync_start_i;
    end else if (parked) begin
      st_d  = ST_HOLD;
      cnt_d = '0;
      lvl_d = ~cfg_i.start_hi;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          if (cfg_i.phase == '0) begin
            st_d  = ST_RUN;
            cnt_d = first_len;
            lvl_d = cfg_i.start_hi;
          end else begin
            st_d  = ST_WAIT;
            cnt_d = cfg_i.phase - 1'b1;
            lvl_d = ~cfg_i.start_hi;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            st_d  = ST_RUN;
            cnt_d = first_len;
            lvl_d = cfg_i.start_hi;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt_q == '0) begin
            lvl_d = ~lvl_q;
            cnt_d = lvl_q ? cfg_i.lo_len : cfg_i.hi_len;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
      lvl_q <= ~RST_CFG.start_hi;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
  assign run_o = (st_q == ST_RUN);

endmodule

// File: rtl/duty_out_sel.sv
`timescale 1ns/1ps
module duty_out_sel
  import duty_div_pkg::*;
(
  input  logic     clk_i,
  input  div_cfg_t cfg_i,
  input  logic     lvl_i,
  output logic     clk_o
);

  always_comb begin
    if (cfg_i.bypass)                          clk_o = clk_i;
    else if (cfg_i.nosync && cfg_i.force_hi)   clk_o = 1'b1;
    else                                       clk_o = lvl_i;
  end

endmodule

// File: rtl/duty_clk_div.sv
`timescale 1ns/1ps
module duty_clk_div
  import duty_div_pkg::*;
#(
  parameter  int NCH = 2,
  localparam int FW  = NCH * CW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_i,
  input  logic [FW-1:0]  cfg_lo_len_i,
  input  logic [FW-1:0]  cfg_hi_len_i,
  input  logic [FW-1:0]  cfg_phase_i,
  input  logic [NCH-1:0] cfg_start_i,
  input  logic [NCH-1:0] cfg_nosync_i,
  input  logic [NCH-1:0] cfg_force_i,
  input  logic [NCH-1:0] cfg_bypass_i,
  output logic [NCH-1:0] clk_o
);

  logic           rst_sync_n;
  logic [NCH-1:0] lvl_w;
  logic [NCH-1:0] run_w;

  duty_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam div_cfg_t RST_C = reset_cfg(c);

    div_cfg_t cfg_in;
    div_cfg_t cfg_act;
    logic     hit;

    always_comb begin
      cfg_in          = '0;
      cfg_in.bypass   = cfg_bypass_i[c];
      cfg_in.nosync   = cfg_nosync_i[c];
      cfg_in.force_hi = cfg_force_i[c];
      cfg_in.start_hi = cfg_start_i[c];
      cfg_in.phase    = cfg_phase_i[c*CW +: CW];
      cfg_in.hi_len   = cfg_hi_len_i[c*CW +: CW];
      cfg_in.lo_len   = cfg_lo_len_i[c*CW +: CW];
    end

    assign hit = sync_i & ~cfg_nosync_i[c];

    duty_cfg_hold #(.RST_CFG(RST_C)) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .capture_i (sync_i),
      .cfg_i     (cfg_in),
      .cfg_o     (cfg_act)
    );

    duty_seq #(.RST_CFG(RST_C)) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_sync_n),
      .cfg_i        (cfg_act),
      .sync_hit_i   (hit),
      .sync_start_i (cfg_start_i[c]),
      .lvl_o        (lvl_w[c]),
      .run_o        (run_w[c])
    );

    duty_out_sel u_out (
      .clk_i (clk_i),
      .cfg_i (cfg_act),
      .lvl_i (lvl_w[c]),
      .clk_o (clk_o[c])
    );
  end

endmodule

// File: rtl/duty_clk_div_chk.sv
`timescale 1ns/1ps
module duty_clk_div_chk
  import duty_div_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic           sync_i,
  input logic [NCH-1:0] cfg_start_i,
  input logic [NCH-1:0] cfg_nosync_i,
  input logic [NCH-1:0] cfg_force_i,
  input logic [NCH-1:0] cfg_bypass_i,
  input logic [NCH-1:0] clk_o,
  input logic [NCH-1:0] lvl_w,
  input logic [NCH-1:0] run_w
);

  localparam logic [CW:0] MAX_RUN = (CW+1)'(1 << CW);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [CW:0] same_q;
    logic        prev_q;

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        same_q <= '0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= lvl_w[c];
        if (!run_w[c])               same_q <= '0;
        else if (lvl_w[c] != prev_q) same_q <= (CW+1)'(1);
        else if (same_q != '1)       same_q <= same_q + 1'b1;
      end
    end

    // R1 / R2: no running interval exceeds sixteen input cycles
    p_run_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
      same_q <= MAX_RUN);

    p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sync_i && !cfg_nosync_i[c]) |=> (lvl_w[c] == !$past(cfg_start_i[c])));

    p_nosync_run_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
      (run_w[c] && sync_i && !$past(sync_i) && cfg_nosync_i[c] &&
       !cfg_force_i[c] && !cfg_bypass_i[c]) |=> run_w[c]);

    p_force_out_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sync_i && cfg_nosync_i[c] && cfg_force_i[c] && !cfg_bypass_i[c]) |=> clk_o[c]);

    p_bypass_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sync_i && cfg_bypass_i[c]) |=> !run_w[c]);
  end

endmodule

bind duty_clk_div duty_clk_div_chk #(.NCH(NCH)) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_sync_n),
  .sync_i       (sync_i),
  .cfg_start_i  (cfg_start_i),
  .cfg_nosync_i (cfg_nosync_i),
  .cfg_force_i  (cfg_force_i),
  .cfg_bypass_i (cfg_bypass_i),
  .clk_o        (clk_o),
  .lvl_w        (lvl_w),
  .run_w        (run_w)
);

// File: tb/duty_clk_div_tb_top.sv
`timescale 1ns/1ps
module duty_clk_div_tb_top;
  import duty_div_pkg::*;

  localparam int NCH = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            sync;
  logic [NCH*CW-1:0] lo, hi, ph;
  logic [NCH-1:0]  st, ns, fh, bp;
  logic [NCH-1:0]  clk_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  s0 [256];
  bit  s1 [256];

  always #2 clk = ~clk;

  duty_clk_div #(.NCH(NCH)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sync_i       (sync),
    .cfg_lo_len_i (lo),
    .cfg_hi_len_i (hi),
    .cfg_phase_i  (ph),
    .cfg_start_i  (st),
    .cfg_nosync_i (ns),
    .cfg_force_i  (fh),
    .cfg_bypass_i (bp),
    .clk_o        (clk_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_ch(int c, int h, int l, int p, bit s, bit n, bit f, bit b);
    hi[c*CW +: CW] = CW'(h);
    lo[c*CW +: CW] = CW'(l);
    ph[c*CW +: CW] = CW'(p);
    st[c] = s; ns[c] = n; fh[c] = f; bp[c] = b;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
  endtask

  task automatic capture(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s0[i] = clk_o[0];
      s1[i] = clk_o[1];
    end
  endtask

  function automatic bit exp_lvl(int i, int h, int l, bit s, int p);
    int j, per, first;
    if (i < p) return !s;
    j     = i - p;
    per   = h + l + 2;
    first = s ? h + 1 : l + 1;
    return ((j % per) < first) ? s : !s;
  endfunction

  task automatic check_model(int c, int n, int h, int l, bit s, int p, string req);
    int bad_i;
    bit a, e;
    bad_i = -1;
    a = 1'b0; e = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit v;
      v = (c == 0) ? s0[i] : s1[i];
      if (bad_i < 0 && v != exp_lvl(i, h, l, s, p)) begin
        bad_i = i; a = v; e = exp_lvl(i, h, l, s, p);
      end
    end
    if (bad_i >= 0)
      $display("FAIL %s ch%0d h=%0d l=%0d start=%0d phase=%0d at sample %0d",
               req, c, h, l, s, p, bad_i);
    check(bad_i < 0, req, "waveform sample", int'(a), int'(e));
  endtask

  task automatic check_runs(int c, int n, int h, int l, string req);
    int prev_t, runs, bad_len, bad_exp;
    bit bad;
    prev_t = -1; runs = 0; bad = 1'b0; bad_len = 0; bad_exp = 0;
    for (int i = 1; i < n; i++) begin
      bit a, b;
      a = (c == 0) ? s0[i]   : s1[i];
      b = (c == 0) ? s0[i-1] : s1[i-1];
      if (a != b) begin
        if (prev_t >= 0) begin
          int len, e;
          len = i - prev_t;
          e   = b ? h + 1 : l + 1;
          runs++;
          if (len != e && !bad) begin
            bad = 1'b1; bad_len = len; bad_exp = e;
          end
        end
        prev_t = i;
      end
    end
    if (runs < 2) check(1'b0, req, "complete runs", runs, 2);
    else          check(!bad, req, "run length", bad_len, bad_exp);
  endtask

  task automatic check_follow(int c, int cycles, string req);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (clk_o[c] !== 1'b1) bad++;
      @(negedge clk); #1;
      if (clk_o[c] !== 1'b0) bad++;
    end
    check(bad == 0, req, "clock follow errors", bad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst_n = 1'b0; sync = 1'b0;
    lo = '0; hi = '0; ph = '0; st = '0; ns = '0; fh = '0; bp = '0;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(clk_o[1] == 1'b1, "R9", "odd channel idle in reset", int'(clk_o[1]), 1);
    check_follow(0, 3, "R9 even channel bypass in reset");

    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    capture(100);
    check_runs(1, 100, 11, 11, "R9 default divide by 24");
    check_follow(0, 4, "R9 R7 default bypass");

    // R1 R2 R3 R4: all length pairs, random start and offsets on both channels
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        int  p0, p1, n;
        bit  a0, a1, f0;
        p0 = int'($urandom % 16);
        p1 = int'($urandom % 16);
        a0 = 1'($urandom);
        a1 = 1'($urandom);
        f0 = 1'($urandom);
        set_ch(0, h, l, p0, a0, 1'b0, f0, 1'b0);
        set_ch(1, h, l, p1, a1, 1'b0, 1'b0, 1'b0);
        n = 16 + 2 * (h + l + 2);
        pulse_sync();
        capture(n);
        check_model(0, n, h, l, a0, p0, "R1 R2 R3 R4 R6");
        check_model(1, n, h, l, a1, p1, "R1 R2 R3 R4");
      end
    end

    // R4: explicit alignment of two channels released together
    set_ch(0, 0, 0, 0,  1'b1, 1'b0, 1'b0, 1'b0);
    set_ch(1, 0, 0, 15, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse_sync();
    capture(20);
    begin
      int f0i, f1i;
      f0i = -1; f1i = -1;
      for (int i = 0; i < 20; i++) begin
        if (f0i < 0 && s0[i]) f0i = i;
        if (f1i < 0 && s1[i]) f1i = i;
      end
      check(f1i - f0i == 15, "R4", "start skew between channels", f1i - f0i, 15);
    end

    // R8: inputs change without sync
    set_ch(1, 3, 3, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_sync();
    set_ch(1, 9, 1, 5, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    capture(80);
    check_runs(1, 80, 3, 3, "R8 no effect without sync");

    // R5: channel ignoring sync keeps running across a pulse
    set_ch(1, 2, 5, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    set_ch(0, 7, 7, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_sync();
    repeat (40) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      s0[i] = clk_o[0];
      s1[i] = clk_o[1];
      sync = (i == 30);
    end
    sync = 1'b0;
    check_runs(1, 100, 2, 5, "R5 nosync continuity");

    // R6: forced high with nosync
    set_ch(1, 2, 5, 0, 1'b0, 1'b1, 1'b1, 1'b0);
    pulse_sync();
    capture(30);
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 30; i++) if (!s1[i]) lows++;
      check(lows == 0, "R6", "low samples while forced", lows, 0);
    end

    // R7: bypass wins over force
    set_ch(1, 2, 5, 0, 1'b0, 1'b1, 1'b1, 1'b1);
    pulse_sync();
    check_follow(1, 8, "R7 bypass over force");

    // R7 R3 R4: leaving bypass restarts cleanly
    set_ch(1, 1, 2, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse_sync();
    capture(40);
    check_model(1, 40, 1, 2, 1'b1, 3, "R7 R3 R4 bypass exit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule